// File: doc/BRIEF.md
# Partitioned Shared FIFO Memory Controller

This block runs two word-wide FIFOs out of one byte-addressed storage array. The array is split at a software-movable boundary. Words below the boundary form the transmit queue and words from the boundary to the top of the array form the receive queue. Each queue has its own circular write and read pointer. Each pointer advances one 32-bit word (four bytes) at a time and wraps back to the first word of its own region, never into the other region.

The host fills the transmit queue and the transmitter drains it. The line side fills the receive queue and the host drains it. A per-frame byte counter watches the transmit pushes. It raises a one-cycle start pulse toward the transmitter once a programmable byte watermark is reached, or earlier when a word marked as the end of its frame is pushed. A small register interface gives access to the watermark code, the boundary, the read-only top address and a set of sticky error flags.

Top module: `split_fifo_ctl`

## Requirements
- R1: After reset both queues are empty and not full, the watermark code reads 0, the status register reads 0 and the boundary register reads its default (512 with default parameters).
- R2: Each queue returns words in the order they were accepted. Read data and its valid strobe appear on the clock edge after the one that takes an accepted pop.
- R3: The transmit queue uses word addresses from 0 up to the boundary minus four bytes. After its last word it wraps to address 0 without disturbing receive data.
- R4: The receive queue uses addresses from the boundary up to the top address inclusive. After the top word it wraps back to the boundary without disturbing transmit data.
- R5: A push into a full queue is dropped and leaves the stored words intact. It sets sticky status bit 0 (transmit) or bit 2 (receive).
- R6: A pop from an empty queue returns no valid strobe. It sets sticky status bit 1 (transmit) or bit 3 (receive).
- R7: Register address 0 holds a 2-bit watermark code: 0 and 1 mean 64 bytes, 2 means 128 bytes and 3 means 192 bytes. The start pulse appears on the edge that accepts the push bringing the frame's byte count to that value.
- R8: An accepted push with the end-of-frame input high raises the start pulse on that edge if the watermark has not yet fired for the frame.
- R9: The start pulse fires at most once per frame. An end-of-frame push restarts the byte count for the next frame.
- R10: Register address 1 holds the boundary as a byte address. A write is rounded down to a 4-byte multiple and clamped to the range 4 to (top address minus 3), so each region keeps at least one word.
- R11: A write to the boundary register empties both queues on that edge and places all pointers at the bases of the new regions.
- R12: Register address 2 reads the highest valid byte address (1023 with default parameters) and ignores writes.
- R13: Register address 3 reads the sticky status bits. Writing a 1 to a bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Host pushes a transmit word |
| tx_wdata | input | 32 | Transmit word to store |
| tx_eof | input | 1 | Pushed word ends its frame |
| tx_full | output | 1 | Transmit region full |
| tx_pop | input | 1 | Transmitter pops a word |
| tx_rdata | output | 32 | Popped transmit word |
| tx_rvalid | output | 1 | tx_rdata valid this cycle |
| tx_empty | output | 1 | Transmit region empty |
| tx_start | output | 1 | One-cycle frame start pulse |
| rx_push | input | 1 | Line side pushes a receive word |
| rx_wdata | input | 32 | Receive word to store |
| rx_full | output | 1 | Receive region full |
| rx_pop | input | 1 | Host pops a receive word |
| rx_rdata | output | 32 | Popped receive word |
| rx_rvalid | output | 1 | rx_rdata valid this cycle |
| rx_empty | output | 1 | Receive region empty |
| reg_addr | input | 2 | Register select |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_addr |

## Verification
A pointer that escapes its region shows up as a word from the other queue coming out of a pop. It can also show up as a queue that fills too early or too late. Both appear within one region's depth of pushes, so the bench uses tiny regions to make that happen in a handful of cycles. A wrong occupancy count shows up as a full or empty flag in the wrong state on the very next edge, or as a missing sticky status bit. A byte counter that is off by a word moves the start pulse by exactly one push, so the bench checks the pulse on every push of each frame rather than only its presence.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;

  localparam int WORD_W  = 32;
  localparam int WORD_BY = 4;

  typedef enum logic [1:0] {
    RA_WMARK   = 2'd0,
    RA_RXSTART = 2'd1,
    RA_BOUND   = 2'd2,
    RA_STATUS  = 2'd3
  } reg_addr_e;

  // bit 0 tx overflow, bit 1 tx underflow, bit 2 rx overflow, bit 3 rx underflow
  typedef struct packed {
    logic rx_unf;
    logic rx_ovf;
    logic tx_unf;
    logic tx_ovf;
  } sticky_t;

  function automatic logic [8:0] wm_bytes(input logic [1:0] code);
    logic [8:0] b;
    case (code)
      2'b10:   b = 9'd128;
      2'b11:   b = 9'd192;
      default: b = 9'd64;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sfc_ram.sv
`timescale 1ns/1ps
module sfc_ram #(
  parameter int DW     = 32,
  parameter int AW     = 8,
  localparam int NWORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [DW-1:0] wd_b,
  input  logic          re_a,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic          re_b,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] mem [NWORDS];

  // Writes from the two regions never target the same word: the regions are disjoint.
  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  always_ff @(posedge clk) begin
    if (re_a) rd_a <= mem[ra_a];
    if (re_b) rd_b <= mem[ra_b];
  end

endmodule

// File: rtl/sfc_region.sv
`timescale 1ns/1ps
module sfc_region #(
  parameter int AW       = 8,
  parameter int RST_BASE = 0,
  localparam int CW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] base_new,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic [CW-1:0] size,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic          empty,
  output logic          ovf_evt,
  output logic          unf_evt
);

  logic [CW-1:0] count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return (p == hi) ? lo : p + AW'(1);
  endfunction

  assign full    = (count == size);
  assign empty   = (count == '0);
  assign push_ok = push & ~full  & ~flush;
  assign pop_ok  = pop  & ~empty & ~flush;
  assign ovf_evt = push & full  & ~flush;
  assign unf_evt = pop  & empty & ~flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= AW'(RST_BASE);
      rptr  <= AW'(RST_BASE);
      count <= '0;
    end else if (flush) begin
      wptr  <= base_new;
      rptr  <= base_new;
      count <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr, first, last);
      if (pop_ok)  rptr <= step(rptr, first, last);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sfc_txgate.sv
`timescale 1ns/1ps
module sfc_txgate #(
  parameter int BW = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic [1:0] wm_code,
  input  logic       push_ok,
  input  logic       eof,
  output logic       tx_start
);

  logic [BW-1:0] frm_bytes;
  logic [BW-1:0] sum;
  logic [BW-1:0] wm;
  logic          fired;
  logic          hit;

  assign wm  = BW'(sfc_pkg::wm_bytes(wm_code));
  assign sum = frm_bytes + BW'(sfc_pkg::WORD_BY);
  assign hit = push_ok & ~fired & ((sum >= wm) | eof);

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_bytes <= '0;
      fired     <= 1'b0;
      tx_start  <= 1'b0;
    end else begin
      tx_start <= hit;
      if (flush) begin
        frm_bytes <= '0;
        fired     <= 1'b0;
      end else if (push_ok) begin
        if (eof) begin
          frm_bytes <= '0;
          fired     <= 1'b0;
        end else begin
          if (!fired) frm_bytes <= sum;
          fired <= fired | hit;
        end
      end
    end
  end

endmodule

// File: rtl/sfc_regs.sv
`timescale 1ns/1ps
module sfc_regs #(
  parameter int ADDR_W = 10,
  parameter int RS_DEF = 512,
  localparam int AW     = ADDR_W - 2,
  localparam int NWORDS = 1 << AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wen,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  sfc_pkg::sticky_t evt,
  output logic [1:0]      wm_code,
  output logic [AW-1:0]   rs_w,
  output logic [AW-1:0]   rs_new,
  output logic            rs_wr
);

  import sfc_pkg::*;

  localparam logic [31:0] BOUND = 32'((1 << ADDR_W) - 1);

  sticky_t     status;
  logic [3:0]  clr;
  reg_addr_e   sel;

  assign sel   = reg_addr_e'(reg_addr);
  assign rs_wr = reg_wen & (sel == RA_RXSTART);
  assign clr   = (reg_wen && sel == RA_STATUS) ? reg_wdata[3:0] : 4'b0;

  always_comb begin
    if (reg_wdata > BOUND) rs_new = AW'(NWORDS - 1);
    else                   rs_new = reg_wdata[ADDR_W-1:2];
    if (rs_new == '0)      rs_new = AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_code <= 2'b00;
      rs_w    <= AW'(RS_DEF / 4);
      status  <= '0;
    end else begin
      if (reg_wen && sel == RA_WMARK) wm_code <= reg_wdata[1:0];
      if (rs_wr)                      rs_w    <= rs_new;
      status <= sticky_t'((status & ~clr) | evt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel)
        RA_WMARK:   reg_rdata <= {30'b0, wm_code};
        RA_RXSTART: reg_rdata <= 32'({rs_w, 2'b00});
        RA_BOUND:   reg_rdata <= BOUND;
        RA_STATUS:  reg_rdata <= {28'b0, status};
        default:    reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/split_fifo_ctl.sv
`timescale 1ns/1ps
module split_fifo_ctl #(
  parameter int ADDR_W = 10,
  parameter int RS_DEF = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_push,
  input  logic [31:0] tx_wdata,
  input  logic        tx_eof,
  output logic        tx_full,
  input  logic        tx_pop,
  output logic [31:0] tx_rdata,
  output logic        tx_rvalid,
  output logic        tx_empty,
  output logic        tx_start,
  input  logic        rx_push,
  input  logic [31:0] rx_wdata,
  output logic        rx_full,
  input  logic        rx_pop,
  output logic [31:0] rx_rdata,
  output logic        rx_rvalid,
  output logic        rx_empty,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  import sfc_pkg::*;

  localparam int AW     = ADDR_W - 2;
  localparam int CW     = AW + 1;
  localparam int NWORDS = 1 << AW;

  logic [AW-1:0] rs_w, rs_new;
  logic          flush;
  logic [1:0]    wm_code;
  sticky_t       evt;

  logic [AW-1:0] tx_wptr, tx_rptr, rx_wptr, rx_rptr;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [CW-1:0] tx_size, rx_size;
  logic [AW-1:0] tx_last, rx_base_new;

  assign tx_size     = {1'b0, rs_w};
  assign rx_size     = CW'(NWORDS) - {1'b0, rs_w};
  assign tx_last     = rs_w - AW'(1);
  assign rx_base_new = rs_new;

  assign evt.tx_ovf = tx_ovf;
  assign evt.tx_unf = tx_unf;
  assign evt.rx_ovf = rx_ovf;
  assign evt.rx_unf = rx_unf;

  sfc_regs #(.ADDR_W(ADDR_W), .RS_DEF(RS_DEF)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt       (evt),
    .wm_code   (wm_code),
    .rs_w      (rs_w),
    .rs_new    (rs_new),
    .rs_wr     (flush)
  );

  sfc_region #(.AW(AW), .RST_BASE(0)) u_txq (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .base_new ('0),
    .first    ('0),
    .last     (tx_last),
    .size     (tx_size),
    .push     (tx_push),
    .pop      (tx_pop),
    .wptr     (tx_wptr),
    .rptr     (tx_rptr),
    .push_ok  (tx_push_ok),
    .pop_ok   (tx_pop_ok),
    .full     (tx_full),
    .empty    (tx_empty),
    .ovf_evt  (tx_ovf),
    .unf_evt  (tx_unf)
  );

  sfc_region #(.AW(AW), .RST_BASE(RS_DEF / 4)) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .base_new (rx_base_new),
    .first    (rs_w),
    .last     (AW'(NWORDS - 1)),
    .size     (rx_size),
    .push     (rx_push),
    .pop      (rx_pop),
    .wptr     (rx_wptr),
    .rptr     (rx_rptr),
    .push_ok  (rx_push_ok),
    .pop_ok   (rx_pop_ok),
    .full     (rx_full),
    .empty    (rx_empty),
    .ovf_evt  (rx_ovf),
    .unf_evt  (rx_unf)
  );

  sfc_ram #(.DW(WORD_W), .AW(AW)) u_ram (
    .clk  (clk),
    .we_a (tx_push_ok),
    .wa_a (tx_wptr),
    .wd_a (tx_wdata),
    .we_b (rx_push_ok),
    .wa_b (rx_wptr),
    .wd_b (rx_wdata),
    .re_a (tx_pop_ok),
    .ra_a (tx_rptr),
    .rd_a (tx_rdata),
    .re_b (rx_pop_ok),
    .ra_b (rx_rptr),
    .rd_b (rx_rdata)
  );

  sfc_txgate #(.BW(9)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wm_code  (wm_code),
    .push_ok  (tx_push_ok),
    .eof      (tx_eof),
    .tx_start (tx_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rvalid <= 1'b0;
      rx_rvalid <= 1'b0;
    end else begin
      tx_rvalid <= tx_pop_ok;
      rx_rvalid <= rx_pop_ok;
    end
  end

endmodule

// File: rtl/sfc_chk.sv
`timescale 1ns/1ps
module sfc_chk #(
  parameter int AW     = 8,
  parameter int ADDR_W = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          tx_start,
  input logic          tx_rvalid,
  input logic          rx_rvalid,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_rdata,
  input logic [AW-1:0] rs_w,
  input logic [AW-1:0] tx_wptr,
  input logic [AW-1:0] tx_rptr,
  input logic [AW-1:0] rx_wptr,
  input logic [AW-1:0] rx_rptr
);

  localparam logic [31:0] BOUND = 32'((1 << ADDR_W) - 1);

  p_rst_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_empty && rx_empty && !tx_full && !rx_full));

  p_tx_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    tx_rvalid |-> ($past(tx_pop) && !$past(tx_empty)));

  p_rx_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    rx_rvalid |-> ($past(rx_pop) && !$past(rx_empty)));

  p_tx_region_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_wptr < rs_w) && (tx_rptr < rs_w));

  p_rx_region_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_wptr >= rs_w) && (rx_rptr >= rs_w));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_push && !tx_pop && !flush) |=> tx_full);

  p_no_rx_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_push && !rx_pop && !flush) |=> rx_full);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && tx_pop) |=> !tx_rvalid);

  p_start_cause_r7: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> ($past(tx_push) && !$past(tx_full) && !$past(flush)));

  p_split_min_r10: assert property (@(posedge clk) disable iff (rst)
    rs_w != '0);

  p_flush_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_empty && rx_empty));

  p_bound_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd2) |=> (reg_rdata == BOUND));

endmodule

bind split_fifo_ctl sfc_chk #(.AW(AW), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .tx_push   (tx_push),
  .tx_pop    (tx_pop),
  .rx_push   (rx_push),
  .rx_pop    (rx_pop),
  .tx_full   (tx_full),
  .tx_empty  (tx_empty),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .tx_start  (tx_start),
  .tx_rvalid (tx_rvalid),
  .rx_rvalid (rx_rvalid),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .rs_w      (rs_w),
  .tx_wptr   (tx_wptr),
  .tx_rptr   (tx_rptr),
  .rx_wptr   (rx_wptr),
  .rx_rptr   (rx_rptr)
);

// File: tb/split_fifo_ctl_tb.sv
`timescale 1ns/1ps
module split_fifo_ctl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        tx_push, tx_eof, tx_pop, rx_push, rx_pop, reg_wen;
  logic [31:0] tx_wdata, rx_wdata, reg_wdata;
  logic [1:0]  reg_addr;
  logic        tx_full, tx_rvalid, tx_empty, tx_start;
  logic        rx_full, rx_rvalid, rx_empty;
  logic [31:0] tx_rdata, rx_rdata, reg_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  split_fifo_ctl u_dut (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_eof(tx_eof), .tx_full(tx_full),
    .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_rvalid(tx_rvalid), .tx_empty(tx_empty),
    .tx_start(tx_start),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_full(rx_full),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_rvalid(rx_rvalid), .rx_empty(rx_empty),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_tx(input logic [31:0] d, input bit eof, output bit start);
    tx_push = 1'b1; tx_wdata = d; tx_eof = eof;
    tick();
    start = tx_start;
    tx_push = 1'b0; tx_eof = 1'b0;
  endtask

  task automatic pop_tx(output logic [31:0] d, output bit v);
    tx_pop = 1'b1;
    tick();
    d = tx_rdata; v = tx_rvalid;
    tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    rx_push = 1'b1; rx_wdata = d;
    tick();
    rx_push = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] d, output bit v);
    rx_pop = 1'b1;
    tick();
    d = rx_rdata; v = rx_rvalid;
    rx_pop = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    tick();
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic expect_tx(input logic [31:0] e, input string req);
    logic [31:0] d; bit v;
    pop_tx(d, v);
    chk(v && d == e, req, v ? d : 32'hDEAD_0000, e);
  endtask

  task automatic expect_rx(input logic [31:0] e, input string req);
    logic [31:0] d; bit v;
    pop_rx(d, v);
    chk(v && d == e, req, v ? d : 32'hDEAD_0000, e);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk(tx_empty && rx_empty, "R1 empty", {tx_empty, rx_empty}, 2'b11);
    chk(!tx_full && !rx_full, "R1 full", {tx_full, rx_full}, 2'b00);
    rd(2'd1, r); chk(r == 32'd512, "R1 boundary", r, 32'd512);
    rd(2'd0, r); chk(r == 32'd0, "R1 watermark", r, 32'd0);
    rd(2'd3, r); chk(r == 32'd0, "R1 status", r, 32'd0);
  endtask

  task automatic t_order();
    bit s;
    for (int i = 0; i < 5; i++) begin
      push_tx(32'hA000_0000 + i, 1'b0, s);
      push_rx(32'hB000_0000 + i);
    end
    for (int i = 0; i < 5; i++) expect_tx(32'hA000_0000 + i, "R2 tx order");
    for (int i = 0; i < 5; i++) expect_rx(32'hB000_0000 + i, "R2 rx order");
    chk(tx_empty && rx_empty, "R2 drained", {tx_empty, rx_empty}, 2'b11);
  endtask

  task automatic t_tx_wrap();
    bit s;
    wr(2'd1, 32'd16);
    push_rx(32'hC0DE_0001);
    for (int i = 0; i < 4; i++) push_tx(32'h30 + i, 1'b0, s);
    chk(tx_full, "R3 full at 4 words", tx_full, 1);
    expect_tx(32'h30, "R3 pop");
    expect_tx(32'h31, "R3 pop");
    push_tx(32'h34, 1'b0, s);
    push_tx(32'h35, 1'b0, s);
    chk(tx_full, "R3 full after wrap", tx_full, 1);
    for (int i = 2; i < 6; i++) expect_tx(32'h30 + i, "R3 wrapped order");
    chk(tx_empty, "R3 empty", tx_empty, 1);
    expect_rx(32'hC0DE_0001, "R3 rx untouched");
  endtask

  task automatic t_rx_wrap();
    bit s;
    wr(2'd1, 32'd1008);
    push_tx(32'hFACE_0001, 1'b0, s);
    for (int i = 0; i < 4; i++) push_rx(32'h40 + i);
    chk(rx_full, "R4 full at 4 words", rx_full, 1);
    expect_rx(32'h40, "R4 pop");
    expect_rx(32'h41, "R4 pop");
    push_rx(32'h44);
    push_rx(32'h45);
    chk(rx_full, "R4 full after wrap", rx_full, 1);
    for (int i = 2; i < 6; i++) expect_rx(32'h40 + i, "R4 wrapped order");
    chk(rx_empty, "R4 empty", rx_empty, 1);
    expect_tx(32'hFACE_0001, "R4 tx untouched");
  endtask

  task automatic t_overflow();
    bit s; logic [31:0] r;
    wr(2'd3, 32'hF);
    wr(2'd1, 32'd16);
    for (int i = 0; i < 4; i++) push_tx(32'h50 + i, 1'b0, s);
    push_tx(32'hBAD0_0BAD, 1'b0, s);
    rd(2'd3, r); chk(r == 32'h1, "R5 tx overflow bit", r, 32'h1);
    for (int i = 0; i < 4; i++) expect_tx(32'h50 + i, "R5 tx contents kept");
    chk(tx_empty, "R5 tx empty", tx_empty, 1);
    wr(2'd1, 32'd1008);
    for (int i = 0; i < 4; i++) push_rx(32'h60 + i);
    push_rx(32'hBAD0_0BAD);
    rd(2'd3, r); chk(r == 32'h5, "R5 rx overflow bit", r, 32'h5);
    for (int i = 0; i < 4; i++) expect_rx(32'h60 + i, "R5 rx contents kept");
  endtask

  task automatic t_underflow();
    logic [31:0] r, d; bit v;
    wr(2'd1, 32'd512);
    wr(2'd3, 32'hF);
    rd(2'd3, r); chk(r == 32'h0, "R13 clear all", r, 32'h0);
    pop_tx(d, v); chk(!v, "R6 tx no valid", v, 0);
    rd(2'd3, r); chk(r == 32'h2, "R6 tx underflow bit", r, 32'h2);
    pop_rx(d, v); chk(!v, "R6 rx no valid", v, 0);
    rd(2'd3, r); chk(r == 32'hA, "R6 rx underflow bit", r, 32'hA);
    wr(2'd3, 32'h2);
    rd(2'd3, r); chk(r == 32'h8, "R13 clear one bit", r, 32'h8);
    wr(2'd3, 32'h0);
    rd(2'd3, r); chk(r == 32'h8, "R13 zero write keeps", r, 32'h8);
  endtask

  task automatic t_watermark();
    bit s;
    for (int code = 0; code < 4; code++) begin
      int need;
      need = (code < 2) ? 16 : code * 16;
      wr(2'd1, 32'd512);
      wr(2'd0, 32'(code));
      for (int i = 1; i <= need + 2; i++) begin
        push_tx(32'(i), 1'b0, s);
        chk(s == (i == need), "R7 start at watermark", {31'(i), s}, {31'(need), 1'b1});
      end
      push_tx(32'hE0F, 1'b1, s);
      chk(!s, "R9 no second start", s, 0);
    end
  endtask

  task automatic t_eof();
    bit s;
    wr(2'd1, 32'd512);
    wr(2'd0, 32'd3);
    for (int i = 0; i < 3; i++) begin
      push_tx(32'(i), 1'b0, s);
      chk(!s, "R8 no early start", s, 0);
    end
    push_tx(32'hE0F, 1'b1, s);
    chk(s, "R8 start on end of frame", s, 1);
    for (int i = 1; i <= 48; i++) begin
      push_tx(32'(i), 1'b0, s);
      chk(s == (i == 48), "R9 count restarts", {31'(i), s}, {31'd48, 1'b1});
    end
  endtask

  task automatic t_clamp();
    logic [31:0] r; bit s;
    logic [31:0] in_v [6] = '{32'h0, 32'h2, 32'h102, 32'h3FF, 32'h1_0000, 32'h200};
    logic [31:0] ex_v [6] = '{32'h4, 32'h4, 32'h100, 32'h3FC, 32'h3FC, 32'h200};
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, in_v[i]);
      rd(2'd1, r);
      chk(r == ex_v[i], "R10 round and clamp", r, ex_v[i]);
    end
    wr(2'd1, 32'h3FF);
    push_rx(32'h1);
    chk(rx_full, "R10 rx keeps one word", rx_full, 1);
    wr(2'd1, 32'h0);
    push_tx(32'h1, 1'b0, s);
    chk(tx_full, "R10 tx keeps one word", tx_full, 1);
  endtask

  task automatic t_flush();
    bit s; logic [31:0] d; bit v;
    wr(2'd1, 32'd512);
    for (int i = 0; i < 3; i++) begin
      push_tx(32'h70 + i, 1'b0, s);
      push_rx(32'h80 + i);
    end
    chk(!tx_empty && !rx_empty, "R11 filled", {tx_empty, rx_empty}, 2'b00);
    wr(2'd1, 32'd256);
    chk(tx_empty && rx_empty, "R11 flushed", {tx_empty, rx_empty}, 2'b11);
    pop_tx(d, v); chk(!v, "R11 tx nothing left", v, 0);
    pop_rx(d, v); chk(!v, "R11 rx nothing left", v, 0);
    push_rx(32'h99);
    expect_rx(32'h99, "R11 new region usable");
  endtask

  task automatic t_bound();
    logic [31:0] r;
    wr(2'd2, 32'h0);
    rd(2'd2, r); chk(r == 32'd1023, "R12 bound read-only", r, 32'd1023);
    rd(2'd1, r); chk(r == 32'd256, "R12 boundary unaffected", r, 32'd256);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst = 1'b1;
    tx_push = 0; tx_eof = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; reg_wen = 0;
    tx_wdata = '0; rx_wdata = '0; reg_wdata = '0; reg_addr = '0;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_order();
    t_tx_wrap();
    t_rx_wrap();
    t_overflow();
    t_underflow();
    t_watermark();
    t_eof();
    t_clamp();
    t_flush();
    t_bound();
    report();
  end

endmodule